// File: doc/BRIEF.md
# Envelope Phase-Lock Loop with Reinforced Quadrature

This block closes a numerically controlled phase-locked loop around an external sliding Fourier filter that extracts the low-frequency envelope of a received signal. Each time the oscillator fires, the block multiplies the current envelope sample by a reinforced quadrature value. That value is the filter's own quadrature output plus a pure cosine read from an internal table. The product is the phase error. A proportional-plus-integral filter with saturating arithmetic turns the error into a correction, and the correction moves the oscillator's frequency word away from its nominal value, within a clamped band.

The oscillator is a phase accumulator. Its carry is a one-clock strobe that the surrounding design uses as the sample strobe of the Fourier filter. The same strobe steps a 7-bit address counter into a 128-entry cosine table, so the table completes one turn per envelope period. With a 50 Hz envelope at 128 samples per period, the strobe rate settles near 6400 Hz. A lock flag rises once the filtered correction has stayed small for a whole window of loop updates.

Top module: `elk_lock_loop`

## Requirements
- R1: The phase accumulator is ACC_W bits wide and adds freq_word on every clock. A carry out of that add raises nco_strobe for exactly the following clock cycle.
- R2: tbl_addr is a 7-bit counter. It advances by one in the cycle after each nco_strobe, wraps from 127 to 0, and holds otherwise.
- R3: cos_out equals COS_AMP·cos(2π·tbl_addr/128), rounded half away from zero, as a SAMPLE_W-bit signed value.
- R4: quad_sum is the combinational sum quad_in + cos_out, SAMPLE_W+1 bits signed.
- R5: At each clock edge where nco_strobe is 1, phase_err takes the signed product env_in·quad_sum (2·SAMPLE_W+1 bits). It holds at every other edge.
- R6: On the edge after a phase_err capture, the integrator becomes sat(integ + (phase_err >>> KI_SH)). sat clamps to the signed range of 2·SAMPLE_W+1 bits.
- R7: On that same edge, loop_ctrl becomes sat(new integ + (phase_err >>> KP_SH)).
- R8: On that same edge, freq_word becomes FREQ_NOM + new loop_ctrl, clamped to [FREQ_NOM−FREQ_SPAN, FREQ_NOM+FREQ_SPAN]. freq_word does not change at any other edge.
- R9: A saturating counter counts consecutive loop updates with |new loop_ctrl| < LOCK_THR. Any other update clears it. locked is 1 exactly while the counter equals LOCK_WIN.
- R10: While rst_n is low, the accumulator, nco_strobe, tbl_addr, phase_err, integrator, loop_ctrl and the lock counter are zero, freq_word is FREQ_NOM, and locked is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| env_in | input | SAMPLE_W | Signed envelope sample |
| quad_in | input | SAMPLE_W | Signed quadrature output of the external Fourier filter |
| nco_strobe | output | 1 | One-clock oscillator pulse, sample strobe for the filter |
| tbl_addr | output | 7 | Cosine table address counter |
| cos_out | output | SAMPLE_W | Signed cosine read from the table |
| quad_sum | output | SAMPLE_W+1 | Reinforced quadrature |
| phase_err | output | 2·SAMPLE_W+1 | Captured correlator product |
| loop_ctrl | output | 2·SAMPLE_W+1 | Filtered correction |
| freq_word | output | ACC_W | Oscillator frequency word |
| locked | output | 1 | Lock indicator |

## Verification
The single-cycle strobe property only holds when freq_word stays below half the accumulator range. The block guarantees this through its clamp, and an elaboration check requires FREQ_NOM+FREQ_SPAN to sit below that limit. The assertions also assume COS_AMP fits the sample width, so the reinforced sum never overflows SAMPLE_W+1 bits. The stimulus keeps env_in and quad_in inside their signed ranges. It runs a small configuration through zero, full-scale positive, full-scale negative and pseudo-random phases. These phases drive the integrator into both saturation limits, the frequency word against both clamp edges, and the lock counter up and back down. The address counter makes many full turns, so every table entry is read.

// File: rtl/elk_pkg.sv
package elk_pkg;
   localparam real ELK_PI = 3.14159265358979323846;

   // cosine table entry, rounded half away from zero
   function automatic int cos_code(int k, int depth, int amp);
      real ang;
      real v;
      ang = 2.0 * ELK_PI * real'(k) / real'(depth);
      v   = real'(amp) * $cos(ang);
      if (v >= 0.0) return $rtoi(v + 0.5);
      else          return -$rtoi(-v + 0.5);
   endfunction
endpackage

// File: rtl/elk_nco.sv
module elk_nco #(
   parameter int ACC_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] freq_word,
   output logic             strobe
);
   logic [ACC_W-1:0] acc;
   logic [ACC_W:0]   sum;

   assign sum = {1'b0, acc} + {1'b0, freq_word};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc    <= '0;
         strobe <= 1'b0;
      end else begin
         acc    <= sum[ACC_W-1:0];
         strobe <= sum[ACC_W];
      end
   end

   // step below half range => never two carries in a row
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe) else $error("strobe wider than one cycle"); // R1
endmodule

// File: rtl/elk_cos_rom.sv
module elk_cos_rom #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 12,
   parameter int AMP    = 1000
) (
   input  logic [ADDR_W-1:0]        addr,
   output logic signed [DATA_W-1:0] data
);
   localparam int DEPTH = 1 << ADDR_W;

   if (AMP >= (1 << (DATA_W - 1))) begin : g_amp_bad
      $error("AMP does not fit DATA_W");
   end

   logic signed [DATA_W-1:0] tbl [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_ent
      localparam int V = elk_pkg::cos_code(k, DEPTH, AMP);
      assign tbl[k] = DATA_W'(V);
   end

   assign data = tbl[addr];
endmodule

// File: rtl/elk_loop_filter.sv
module elk_loop_filter #(
   parameter int ERR_W     = 25,
   parameter int ACC_W     = 24,
   parameter int FREQ_NOM  = 2147,
   parameter int FREQ_SPAN = 256,
   parameter int KI_SH     = 10,
   parameter int KP_SH     = 6,
   parameter bit PROP_EN   = 1'b1,
   parameter int LOCK_THR  = 4096,
   parameter int LOCK_WIN  = 256
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    err_vld,
   input  logic signed [ERR_W-1:0] err,
   output logic signed [ERR_W-1:0] ctrl,
   output logic [ACC_W-1:0]        freq_word,
   output logic                    locked
);
   localparam longint EMAX  = (longint'(1) <<< (ERR_W - 1)) - 1;
   localparam longint EMIN  = -EMAX - 1;
   localparam longint F_LO  = longint'(FREQ_NOM) - longint'(FREQ_SPAN);
   localparam longint F_HI  = longint'(FREQ_NOM) + longint'(FREQ_SPAN);
   localparam int     CNT_W = $clog2(LOCK_WIN + 1);

   if (ERR_W > 60)            begin : g_w_bad   $error("ERR_W too wide"); end
   if (KI_SH >= ERR_W)        begin : g_ki_bad  $error("KI_SH too large"); end
   if (KP_SH >= ERR_W)        begin : g_kp_bad  $error("KP_SH too large"); end
   if (LOCK_WIN < 1)          begin : g_win_bad $error("LOCK_WIN must be positive"); end

   function automatic logic signed [ERR_W-1:0] sat(input longint v);
      if (v > EMAX)      return ERR_W'(EMAX);
      else if (v < EMIN) return ERR_W'(EMIN);
      else               return ERR_W'(v);
   endfunction

   logic signed [ERR_W-1:0] integ, integ_n, ctrl_n;
   logic [CNT_W-1:0]        cnt;
   longint                  f_raw, mag_n;
   logic [ACC_W-1:0]        f_n;

   assign integ_n = sat(longint'(integ) + longint'(err >>> KI_SH));

   if (PROP_EN) begin : g_pi
      assign ctrl_n = sat(longint'(integ_n) + longint'(err >>> KP_SH));
   end else begin : g_i
      assign ctrl_n = integ_n;
   end

   always_comb begin
      f_raw = longint'(FREQ_NOM) + longint'(ctrl_n);
      if (f_raw > F_HI)      f_n = ACC_W'(F_HI);
      else if (f_raw < F_LO) f_n = ACC_W'(F_LO);
      else                   f_n = ACC_W'(f_raw);
      mag_n = (ctrl_n < 0) ? -longint'(ctrl_n) : longint'(ctrl_n);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         integ     <= '0;
         ctrl      <= '0;
         freq_word <= ACC_W'(FREQ_NOM);
         cnt       <= '0;
      end else if (err_vld) begin
         integ     <= integ_n;
         ctrl      <= ctrl_n;
         freq_word <= f_n;
         if (mag_n < longint'(LOCK_THR)) begin
            if (cnt != CNT_W'(LOCK_WIN)) cnt <= cnt + 1'b1;
         end else begin
            cnt <= '0;
         end
      end
   end

   assign locked = (cnt == CNT_W'(LOCK_WIN));

   AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !err_vld |=> $stable(freq_word)) else $error("freq moved without update"); // R8
   AST_LOCK_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> ((ctrl < 0 ? -longint'(ctrl) : longint'(ctrl)) < longint'(LOCK_THR)))
      else $error("locked with large correction"); // R9
   AST_INTEG_NOWRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (err_vld && integ > 0 && err >= 0) |=> integ >= $past(integ))
      else $error("integrator wrapped"); // R6
endmodule

// File: rtl/elk_lock_loop.sv
module elk_lock_loop #(
   parameter int SAMPLE_W  = 12,
   parameter int ACC_W     = 24,
   parameter int FREQ_NOM  = 2147,
   parameter int FREQ_SPAN = 256,
   parameter int COS_AMP   = 1000,
   parameter int KI_SH     = 10,
   parameter int KP_SH     = 6,
   parameter bit PROP_EN   = 1'b1,
   parameter int LOCK_THR  = 4096,
   parameter int LOCK_WIN  = 256
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic signed [SAMPLE_W-1:0]  env_in,
   input  logic signed [SAMPLE_W-1:0]  quad_in,
   output logic                        nco_strobe,
   output logic [6:0]                  tbl_addr,
   output logic signed [SAMPLE_W-1:0]  cos_out,
   output logic signed [SAMPLE_W:0]    quad_sum,
   output logic signed [2*SAMPLE_W:0]  phase_err,
   output logic signed [2*SAMPLE_W:0]  loop_ctrl,
   output logic [ACC_W-1:0]            freq_word,
   output logic                        locked
);
   localparam int ADDR_W = 7;
   localparam int PW     = 2 * SAMPLE_W + 1;

   if (FREQ_SPAN >= FREQ_NOM) begin : g_span_bad
      $error("FREQ_SPAN must be below FREQ_NOM");
   end
   if (longint'(FREQ_NOM) + longint'(FREQ_SPAN) >= (longint'(1) <<< (ACC_W - 1))) begin : g_top_bad
      $error("frequency band must stay below half the accumulator range");
   end

   logic                 err_vld;
   logic signed [PW-1:0] prod;

   elk_nco #(.ACC_W(ACC_W)) u_nco (
      .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .strobe(nco_strobe)
   );

   elk_cos_rom #(.ADDR_W(ADDR_W), .DATA_W(SAMPLE_W), .AMP(COS_AMP)) u_rom (
      .addr(tbl_addr), .data(cos_out)
   );

   elk_loop_filter #(
      .ERR_W(PW), .ACC_W(ACC_W), .FREQ_NOM(FREQ_NOM), .FREQ_SPAN(FREQ_SPAN),
      .KI_SH(KI_SH), .KP_SH(KP_SH), .PROP_EN(PROP_EN),
      .LOCK_THR(LOCK_THR), .LOCK_WIN(LOCK_WIN)
   ) u_filt (
      .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err(phase_err),
      .ctrl(loop_ctrl), .freq_word(freq_word), .locked(locked)
   );

   // reinforced quadrature and correlator
   assign quad_sum = {quad_in[SAMPLE_W-1], quad_in} + {cos_out[SAMPLE_W-1], cos_out};
   assign prod     = PW'(env_in) * PW'(quad_sum);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl_addr  <= '0;
         phase_err <= '0;
         err_vld   <= 1'b0;
      end else begin
         err_vld <= nco_strobe;
         if (nco_strobe) begin
            tbl_addr  <= tbl_addr + 1'b1;
            phase_err <= prod;
         end
      end
   end

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      nco_strobe |=> tbl_addr == $past(tbl_addr) + 7'd1) else $error("address skipped"); // R2
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !nco_strobe |=> $stable(tbl_addr)) else $error("address drifted"); // R2
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !nco_strobe |=> $stable(phase_err)) else $error("error changed off strobe"); // R5
endmodule

// File: tb/elk_lock_loop_test.sv
module elk_lock_loop_test;
   localparam int W    = 8;
   localparam int A    = 10;
   localparam int NOM  = 100;
   localparam int SPAN = 40;
   localparam int AMP  = 100;
   localparam int KI   = 6;
   localparam int KP   = 4;
   localparam int THR  = 50;
   localparam int WIN  = 8;
   localparam int PW   = 2 * W + 1;
   localparam longint EMAX = (longint'(1) <<< (PW - 1)) - 1;
   localparam longint EMIN = -EMAX - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic signed [W-1:0]  env_in = '0;
   logic signed [W-1:0]  quad_in = '0;
   logic                 nco_strobe;
   logic [6:0]           tbl_addr;
   logic signed [W-1:0]  cos_out;
   logic signed [W:0]    quad_sum;
   logic signed [PW-1:0] phase_err;
   logic signed [PW-1:0] loop_ctrl;
   logic [A-1:0]         freq_word;
   logic                 locked;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   elk_lock_loop #(
      .SAMPLE_W(W), .ACC_W(A), .FREQ_NOM(NOM), .FREQ_SPAN(SPAN), .COS_AMP(AMP),
      .KI_SH(KI), .KP_SH(KP), .PROP_EN(1'b1), .LOCK_THR(THR), .LOCK_WIN(WIN)
   ) uut (.*);

   // model state
   longint m_acc, m_addr, m_err, m_integ, m_ctrl, m_freq, m_cnt;
   bit     m_strobe, m_vld;
   longint m_env, m_quad;

   function automatic longint cosv(longint k);
      real v;
      v = real'(AMP) * $cos(2.0 * 3.14159265358979323846 * real'(k) / 128.0);
      if (v >= 0.0) return longint'($rtoi(v + 0.5));
      else          return -longint'($rtoi(-v + 0.5));
   endfunction

   function automatic longint sat(longint v);
      if (v > EMAX) return EMAX;
      if (v < EMIN) return EMIN;
      return v;
   endfunction

   task automatic check(string tag, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_acc = 0; m_addr = 0; m_err = 0; m_integ = 0; m_ctrl = 0;
      m_freq = NOM; m_cnt = 0; m_strobe = 0; m_vld = 0;
   endtask

   task automatic compare_all();
      longint cv;
      cv = cosv(m_addr);
      check("R1", "nco_strobe", longint'(nco_strobe), longint'(m_strobe));
      check("R2", "tbl_addr", longint'(tbl_addr), m_addr);
      check("R3", "cos_out", longint'(cos_out), cv);
      check("R4", "quad_sum", longint'(quad_sum), m_quad + cv);
      check("R5", "phase_err", longint'(phase_err), m_err);
      check("R7", "loop_ctrl", longint'(loop_ctrl), m_ctrl);
      check("R8", "freq_word", longint'(freq_word), m_freq);
      check("R9", "locked", longint'(locked), longint'(m_cnt == WIN));
   endtask

   // at a negedge: check, apply new inputs, advance model to next posedge
   task automatic step(longint env, longint quad);
      longint sum, prod, ni, nc, nf, mag;
      @(negedge clk);
      compare_all();
      env_in  = W'(env);
      quad_in = W'(quad);
      m_env = env; m_quad = quad;
      prod = m_env * (m_quad + cosv(m_addr));
      sum  = m_acc + m_freq;
      if (m_vld) begin
         ni = sat(m_integ + (m_err >>> KI));                 // R6
         nc = sat(ni + (m_err >>> KP));                      // R7
         nf = NOM + nc;
         if (nf > NOM + SPAN) nf = NOM + SPAN;               // R8
         if (nf < NOM - SPAN) nf = NOM - SPAN;
         mag = (nc < 0) ? -nc : nc;
         if (mag < THR) m_cnt = (m_cnt == WIN) ? WIN : m_cnt + 1;  // R9
         else m_cnt = 0;
         m_integ = ni; m_ctrl = nc; m_freq = nf;
      end
      m_vld = m_strobe;
      if (m_strobe) begin
         m_addr = (m_addr + 1) % 128;
         m_err  = prod;
      end
      m_strobe = (sum >= (1 << A));
      m_acc    = sum % (1 << A);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      env_in = '0; quad_in = '0; m_env = 0; m_quad = 0;
      repeat (3) @(negedge clk);
      model_reset();
      // R10: reset state
      check("R10", "reset nco_strobe", longint'(nco_strobe), 0);
      check("R10", "reset tbl_addr", longint'(tbl_addr), 0);
      check("R10", "reset phase_err", longint'(phase_err), 0);
      check("R10", "reset loop_ctrl", longint'(loop_ctrl), 0);
      check("R10", "reset freq_word", longint'(freq_word), NOM);
      check("R10", "reset locked", longint'(locked), 0);
      rst_n = 1'b1;
      // model advances from reset with the held zero inputs
      begin
         longint sum;
         sum = m_acc + m_freq;
         m_strobe = (sum >= (1 << A));
         m_acc = sum % (1 << A);
      end
   endtask

   logic [15:0] lfsr = 16'hACE1;

   initial begin
      model_reset();
      m_env = 0; m_quad = 0;
      do_reset();
      // zero input: error stays zero, loop must lock at nominal
      repeat (2000) step(0, 0);
      check("R9", "lock after quiet run", longint'(locked), 1);
      check("R8", "nominal word while quiet", longint'(freq_word), NOM);
      // full-scale positive: integrator saturates high, word clamps high
      repeat (12000) step(127, 127);
      check("R8", "upper clamp", longint'(freq_word), NOM + SPAN);
      check("R6", "integrator high saturation via ctrl", longint'(loop_ctrl), EMAX);
      // full-scale negative product: drive the other way
      repeat (12000) step(-128, 127);
      check("R8", "lower clamp", longint'(freq_word), NOM - SPAN);
      check("R6", "integrator low saturation via ctrl", longint'(loop_ctrl), EMIN);
      // pseudo-random samples
      for (int i = 0; i < 8000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(longint'($signed(lfsr[7:0])), longint'($signed(lfsr[15:8])));
      end
      // mid-run reset then small alternating input near lock threshold
      do_reset();
      for (int i = 0; i < 3000; i++) step((i % 2) ? 1 : -1, 2);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule